// File: doc/BRIEF.md
# Serial Unlock Pattern Recognizer

This block sits beside a parallel SRAM socket and watches its bus cycles. It turns the chip-enable, output-enable and write-enable strobes into completed read and write cycles, and uses them to look for a fixed 64-bit key that arrives one bit per write cycle on data bit 0. A read cycle arms the search and rewinds the comparison pointer to the first key bit. Each write whose data bit 0 equals the key bit at the pointer moves the pointer on by one. A write that does not match freezes the search, and later writes have no effect until a read arms it again.

When the last key bit matches, the block gives a one-clock unlock pulse to a downstream serial transfer unit. It then diverts the next block of chip-enabled cycles away from the RAM by driving the RAM-select output low. After that block of cycles it returns to the disarmed state. No address is involved: every cycle in the device's range takes part, and every cycle up to and including the one that completes the key still reaches the RAM.

Top module: `unlock_seq_detect`

## Requirements
- R1: After reset the recognizer is disarmed, unlock_o is 0 and ram_sel_o is 1. Writes of the full key with no read before them give no unlock.
- R2: A cycle counts once, at the first clock after its strobe ends. The strobe is active while ce_ni is 0 and we_ni or oe_ni is 0. The cycle is a write if we_ni was 0 in the last active sample, and a read otherwise. Samples with ce_ni at 1 are ignored, as are samples with ce_ni at 0 and both other strobes at 1. Neither kind advances, freezes nor aborts the sequence.
- R3: A read cycle arms the recognizer and sets the pointer to key bit 0.
- R4: While armed, a write whose dq0_i equals KEY[pointer] advances the pointer by one. Bit 0 of KEY is compared first.
- R5: While armed, a write whose dq0_i differs from KEY[pointer] freezes the pointer. All later writes are ignored until a read.
- R6: A read cycle at any point during recognition, including just before the last bit, aborts the sequence and restarts it at key bit 0.
- R7: A match on key bit KEY_W-1 drives unlock_o high for exactly one clock, starting on the clock that counts that write.
- R8: ram_sel_o stays 1 through every cycle before the key completes, including the completing write itself.
- R9: After unlock, ram_sel_o is 0 for the next XFER_LEN chip-enabled cycles, reads or writes, and reads do not abort this phase. The block then returns to disarmed with ram_sel_o at 1 and needs a new read before the key is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the bus strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable of the socket, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| dq0_i | input | 1 | Data bit 0 of the bus |
| unlock_o | output | 1 | One-clock pulse when the full key has matched |
| ram_sel_o | output | 1 | 1 while bus cycles belong to the RAM |

## Verification
On every cycle the assertions check these rules: the unlock pulse lasts one clock, and it coincides with the RAM being deselected. They also check that a read outside the transfer phase always leaves the recognizer armed at bit 0, that a frozen search stays frozen until a read, that the pointer holds when no cycle completes, and that the transfer counter stays in range. Only the bench scenarios can show the outcome of a whole sequence. That covers a full key unlocking, a key with no read before it staying locked, one wrong bit spoiling the rest of a correct key, and an abort just before the last bit. It also covers interleaved cycles with chip enable high changing nothing, a long write strobe counting once, and ram_sel_o being 1 during the completing write and 0 for exactly the transfer window.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_FROZEN = 2'd2,
    ST_DIVERT = 2'd3
  } ustate_e;
endpackage

// File: rtl/bus_cycle_decode.sv
module bus_cycle_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic dq0_i,
  output logic wr_o,
  output logic rd_o,
  output logic bit_o
);
  logic act_now, act_q, wr_q, bit_q, done;

  assign act_now = ~ce_ni & (~we_ni | ~oe_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      act_q <= act_now;
      if (act_now) begin
        wr_q  <= ~we_ni;
        bit_q <= dq0_i;
      end
    end
  end

  // cycle ends on the trailing edge of the combined strobe
  assign done  = act_q & ~act_now;
  assign wr_o  = done & wr_q;
  assign rd_o  = done & ~wr_q;
  assign bit_o = bit_q;

  assert_ce_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && $past(ce_ni)) |-> !(wr_o || rd_o));
endmodule

// File: rtl/key_matcher.sv
module key_matcher
  import unlock_pkg::*;
#(
  parameter int          KEY_W    = 64,
  parameter logic [63:0] KEY      = 64'hA5C3_3C5A_96E1_1E69,
  parameter int          XFER_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic rd_i,
  input  logic bit_i,
  output logic unlock_o,
  output logic ram_sel_o
);
  localparam int PTR_W = $clog2(KEY_W);
  localparam int CNT_W = $clog2(XFER_LEN + 1);

  ustate_e          state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             unlock_q, unlock_d;
  logic             key_bit, last_bit, last_xfer;

  assign key_bit   = KEY[ptr_q];
  assign last_bit  = (ptr_q == PTR_W'(KEY_W - 1));
  assign last_xfer = (cnt_q == CNT_W'(XFER_LEN - 1));

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    cnt_d    = cnt_q;
    unlock_d = 1'b0;
    if (state_q == ST_DIVERT) begin
      if (wr_i || rd_i) begin
        if (last_xfer) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (rd_i) begin
      state_d = ST_ARMED;
      ptr_d   = '0;
    end else if (wr_i && state_q == ST_ARMED) begin
      if (bit_i == key_bit) begin
        if (last_bit) begin
          state_d  = ST_DIVERT;
          ptr_d    = '0;
          cnt_d    = '0;
          unlock_d = 1'b1;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end else begin
        state_d = ST_FROZEN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      cnt_q    <= '0;
      unlock_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      cnt_q    <= cnt_d;
      unlock_q <= unlock_d;
    end
  end

  assign unlock_o  = unlock_q;
  assign ram_sel_o = (state_q != ST_DIVERT);

  assert_unlock_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_q |=> !unlock_q);
  assert_unlock_diverts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_q |-> !ram_sel_o);
  assert_divert_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIVERT) |-> (cnt_q < CNT_W'(XFER_LEN)));
  assert_read_rewinds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state_q != ST_DIVERT) |=> (state_q == ST_ARMED && ptr_q == '0));
  assert_frozen_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FROZEN && !rd_i) |=> (state_q == ST_FROZEN));
  assert_ptr_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && !rd_i && !wr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect #(
  parameter int          KEY_W    = 64,
  parameter logic [63:0] KEY      = 64'hA5C3_3C5A_96E1_1E69,
  parameter int          XFER_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic dq0_i,
  output logic unlock_o,
  output logic ram_sel_o
);
  logic cyc_wr, cyc_rd, cyc_bit;

  bus_cycle_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .oe_ni  (oe_ni),
    .we_ni  (we_ni),
    .dq0_i  (dq0_i),
    .wr_o   (cyc_wr),
    .rd_o   (cyc_rd),
    .bit_o  (cyc_bit)
  );

  key_matcher #(
    .KEY_W    (KEY_W),
    .KEY      (KEY),
    .XFER_LEN (XFER_LEN)
  ) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cyc_wr),
    .rd_i      (cyc_rd),
    .bit_i     (cyc_bit),
    .unlock_o  (unlock_o),
    .ram_sel_o (ram_sel_o)
  );
endmodule

// File: tb/sim_unlock_seq_detect.sv
`timescale 1ns/1ps
module sim_unlock_seq_detect;
  localparam logic [63:0] KEY = 64'hA5C3_3C5A_96E1_1E69;

  localparam logic [2:0] OP_RD   = 3'd0;
  localparam logic [2:0] OP_KEY  = 3'd1;
  localparam logic [2:0] OP_BAD  = 3'd2;
  localparam logic [2:0] OP_NOCE = 3'd3;
  localparam logic [2:0] OP_XRD  = 3'd4;
  localparam logic [2:0] OP_XWR  = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [6:0] n;
    logic [1:0] exp_unl;
    logic       exp_ram;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_KEY, 7'd64, 2'd0, 1'b1},  // R1 no read first
    '{OP_RD,  7'd1,  2'd0, 1'b1},  // R3
    '{OP_KEY, 7'd64, 2'd1, 1'b0},  // R4 R7
    '{OP_XRD, 7'd63, 2'd0, 1'b0},  // R9
    '{OP_XRD, 7'd1,  2'd0, 1'b1},  // R9
    '{OP_KEY, 7'd64, 2'd0, 1'b1},  // R9 disarmed
    '{OP_RD,  7'd1,  2'd0, 1'b1},
    '{OP_KEY, 7'd10, 2'd0, 1'b1},
    '{OP_BAD, 7'd1,  2'd0, 1'b1},
    '{OP_KEY, 7'd54, 2'd0, 1'b1},  // R5
    '{OP_RD,  7'd1,  2'd0, 1'b1},
    '{OP_KEY, 7'd20, 2'd0, 1'b1},
    '{OP_RD,  7'd1,  2'd0, 1'b1},  // R6
    '{OP_KEY, 7'd64, 2'd1, 1'b0},
    '{OP_XWR, 7'd64, 2'd0, 1'b1},
    '{OP_RD,  7'd1,  2'd0, 1'b1},
    '{OP_KEY, 7'd30, 2'd0, 1'b1},
    '{OP_NOCE,7'd6,  2'd0, 1'b1},  // R2
    '{OP_KEY, 7'd34, 2'd1, 1'b0},
    '{OP_XWR, 7'd64, 2'd0, 1'b1},
    '{OP_RD,  7'd1,  2'd0, 1'b1},
    '{OP_KEY, 7'd63, 2'd0, 1'b1},
    '{OP_RD,  7'd1,  2'd0, 1'b1},  // R6 last bit
    '{OP_KEY, 7'd64, 2'd1, 1'b0},
    '{OP_XRD, 7'd64, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq0 = 1'b0;
  logic unlock, ram_sel;
  int   n_chk = 0, n_fail = 0, unl_cnt = 0;
  logic [6:0] bidx = '0;
  logic last_ram = 1'b1;
  bit   done_flag = 1'b0;

  always #5 clk = ~clk;

  unlock_seq_detect u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ce_ni     (ce_n),
    .oe_ni     (oe_n),
    .we_ni     (we_n),
    .dq0_i     (dq0),
    .unlock_o  (unlock),
    .ram_sel_o (ram_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one bus cycle: active phase, release, sample
  task automatic bus_cycle(input logic ce, input logic wr, input logic rd, input logic d);
    @(negedge clk);
    ce_n = ~ce; we_n = ~wr; oe_n = ~rd; dq0 = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    if (unlock) unl_cnt++;
    last_ram = ram_sel;
  endtask

  task automatic run_op(input logic [2:0] op, input int n);
    for (int i = 0; i < n; i++) begin
      case (op)
        OP_RD:   begin bus_cycle(1'b1, 1'b0, 1'b1, 1'b0); bidx = '0; end
        OP_KEY:  begin bus_cycle(1'b1, 1'b1, 1'b0, KEY[bidx[5:0]]); bidx++; end
        OP_BAD:  bus_cycle(1'b1, 1'b1, 1'b0, ~KEY[bidx[5:0]]);
        OP_NOCE: bus_cycle(1'b0, (i % 2) == 0, (i % 2) == 1, ~KEY[bidx[5:0]]);
        OP_XRD:  bus_cycle(1'b1, 1'b0, 1'b1, 1'b0);
        default: bus_cycle(1'b1, 1'b1, 1'b0, 1'b0);
      endcase
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(unlock == 1'b0, "R1 reset unlock", unlock, 0);
    check(ram_sel == 1'b1, "R1 reset ram_sel", ram_sel, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      unl_cnt = 0;
      run_op(VECS[v].op, int'(VECS[v].n));
      check(unl_cnt == int'(VECS[v].exp_unl), $sformatf("R7 vec%0d unlock count", v),
            unl_cnt, VECS[v].exp_unl);
      check(last_ram == VECS[v].exp_ram, $sformatf("R9 vec%0d ram_sel", v),
            last_ram, VECS[v].exp_ram);
    end

    // R8: ram_sel high during the completing write, low after it
    run_op(OP_RD, 1);
    unl_cnt = 0;
    run_op(OP_KEY, 63);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; dq0 = KEY[63];
    @(negedge clk);
    check(ram_sel == 1'b1, "R8 completing write ram_sel", ram_sel, 1);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    check(unlock == 1'b1, "R7 unlock pulse", unlock, 1);
    check(ram_sel == 1'b0, "R9 divert after key", ram_sel, 0);
    @(negedge clk);
    check(unlock == 1'b0, "R7 pulse one clock", unlock, 0);
    run_op(OP_XWR, 64);

    // R2: ce low with no strobe is ignored; long write counts once
    run_op(OP_RD, 1);
    bus_cycle(1'b1, 1'b0, 1'b0, ~KEY[0]);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; dq0 = KEY[0];
    repeat (3) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    bidx = 7'd1;
    unl_cnt = 0;
    run_op(OP_KEY, 63);
    check(unl_cnt == 1, "R2 idle ce and long write", unl_cnt, 1);
    run_op(OP_XWR, 64);
    check(last_ram == 1'b1, "R9 ram back", last_ram, 1);

    // R1: reset mid-sequence disarms
    run_op(OP_RD, 1);
    run_op(OP_KEY, 40);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ram_sel == 1'b1, "R1 reset mid ram_sel", ram_sel, 1);
    rst_n = 1'b1;
    unl_cnt = 0;
    run_op(OP_KEY, 24);
    check(unl_cnt == 0, "R1 reset disarms", unl_cnt, 0);

    done_flag = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
    end
  end
endmodule